// File: doc/BRIEF.md
# Workspace Context Switch Sequencer

This block performs the context switches of a small 16-bit processor that keeps only three registers on chip: a program counter, a status word and a workspace pointer. The sixteen general registers are ordinary RAM words located relative to the workspace pointer. Because of this, a subroutine call or an interrupt never pushes registers onto a stack. It moves the workspace pointer to a fresh register set and stores the three on-chip registers of the old context inside that new set.

The instruction decoder issues four kinds of command. The first replaces the workspace pointer directly. The second performs a call through a two-word vector in memory. The third returns by reloading all three registers from the current workspace. The fourth encoding does nothing. An interrupt request carrying a level code is taken at an instruction boundary if its level passes the mask held in the status word. It then goes through the same vectored switch, using a vector slot fixed by its level. Memory is reached through a single synchronous word port. Read data appears one cycle after the request.

Top module: `wsctx_top`

## Requirements
- R1: After reset, pcOut is 0x0100, wpOut is 0x0080, stOut is 0x000F, and busy and memReq are low.
- R2: When idle, a command with cmdOp=0 and no interrupt taken loads cmdArg into wpOut on the next clock. It makes no memory access, does not raise busy and leaves pcOut and stOut unchanged.
- R3: When idle, a command with cmdOp=1 uses cmdArg as a vector address. The word at cmdArg becomes the new workspace pointer and the word at cmdArg+2 becomes the new program counter. The status word is unchanged.
- R4: A request at level n, with 0 <= n <= 15, is taken when the block is idle, boundary is high and n <= stOut[3:0]. Its vector is read from byte address 4*n, with the workspace pointer first and the program counter second.
- R5: In every vectored switch, the old workspace pointer, old program counter and old status word are written in that order to byte addresses newWP+26, newWP+28 and newWP+30. All three writes happen before the new context becomes visible.
- R6: A command with cmdOp=2 reads currentWP+26, +28 and +30 and reloads the workspace pointer, the program counter and the status word from them. Memory is not written.
- R7: A taken interrupt sets stOut[3:0] to n-1, or to 0 when n is 0, and keeps stOut[15:4]. A request whose level is above the mask, or that arrives while boundary is low, is not taken.
- R8: busy stays high for exactly 5 cycles during a vectored switch and exactly 4 cycles during a return. The new context is visible in the first cycle with busy low. Commands and requests that arrive while busy is high are ignored.
- R9: If an interrupt is taken in the same idle cycle as a valid command, the interrupt wins and the command is dropped. cmdOp=3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present from the decoder |
| cmdOp | input | 2 | 0 load WP, 1 vectored call, 2 return, 3 none |
| cmdArg | input | 16 | New WP or vector address |
| boundary | input | 1 | Instruction boundary, interrupts may be taken |
| irqReq | input | 1 | Interrupt request |
| irqLevel | input | 4 | Interrupt level |
| memReq | output | 1 | Memory access this cycle |
| memWe | output | 1 | Access is a write |
| memAddr | output | 16 | Byte address of the word |
| memWdata | output | 16 | Write data |
| memRdata | input | 16 | Read data, one cycle after a read request |
| pcOut | output | 16 | Program counter |
| stOut | output | 16 | Status word, mask in bits 3:0 |
| wpOut | output | 16 | Workspace pointer |
| busy | output | 1 | Switch or return in progress |

## Verification
An accepted command or request is registered on one edge. From the next cycle, busy stays high for five cycles for a vectored switch or four for a return, and the new context is committed on the edge where busy falls. A WP load shows on the edge where it is accepted. The bench drives inputs on falling edges and then advances one falling edge at a time while busy is high, counting the busy cycles. It compares the registers and the whole memory image only at the first falling edge with busy low, and it checks the order of the save writes from a log of write addresses. The expected values come from a bench model of memory and registers.

// File: rtl/wsctx_pkg.sv
package wsctx_pkg;

  typedef enum logic [1:0] {
    OP_LOADWP = 2'd0,
    OP_CALL   = 2'd1,
    OP_RETURN = 2'd2,
    OP_NONE   = 2'd3
  } cmdOp_e;

  typedef enum logic [2:0] {
    AS_VEC0    = 3'd0,
    AS_VEC1    = 3'd1,
    AS_SAVE_WP = 3'd2,
    AS_SAVE_PC = 3'd3,
    AS_SAVE_ST = 3'd4,
    AS_RET_WP  = 3'd5,
    AS_RET_PC  = 3'd6,
    AS_RET_ST  = 3'd7
  } addrSel_e;

  typedef struct packed {
    logic     memReq;
    logic     memWe;
    addrSel_e addrSel;
    logic     latchVec;
    logic     vecFromIrq;
    logic     capWp;
    logic     capPc;
    logic     commitCall;
    logic     commitRet;
    logic     loadWpImm;
  } dpCtl_t;

endpackage

// File: rtl/wsctx_ctrl.sv
module wsctx_ctrl
  import wsctx_pkg::*;
#(
  parameter int MASK_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic              boundary,
  input  logic              irqReq,
  input  logic [MASK_W-1:0] irqLevel,
  input  logic [MASK_W-1:0] stMask,
  output dpCtl_t            ctl,
  output logic              busy
);

  typedef enum logic [3:0] {
    ST_IDLE, ST_VR0, ST_VR1, ST_W13, ST_W14, ST_W15,
    ST_RT0, ST_RT1, ST_RT2, ST_RT3
  } seqState_e;

  seqState_e stateQ, stateD;
  logic irqOk, cmdOk;

  always_comb begin
    irqOk  = (stateQ == ST_IDLE) && boundary && irqReq && (irqLevel <= stMask);
    cmdOk  = (stateQ == ST_IDLE) && cmdValid && !irqOk;
    ctl    = '0;
    stateD = stateQ;
    case (stateQ)
      ST_IDLE: begin
        if (irqOk) begin
          ctl.latchVec   = 1'b1;
          ctl.vecFromIrq = 1'b1;
          stateD         = ST_VR0;
        end else if (cmdOk) begin
          case (cmdOp_e'(cmdOp))
            OP_LOADWP: ctl.loadWpImm = 1'b1;
            OP_CALL: begin
              ctl.latchVec = 1'b1;
              stateD       = ST_VR0;
            end
            OP_RETURN: stateD = ST_RT0;
            default: ;
          endcase
        end
      end
      ST_VR0: begin
        ctl.memReq  = 1'b1;
        ctl.addrSel = AS_VEC0;
        stateD      = ST_VR1;
      end
      ST_VR1: begin
        ctl.memReq  = 1'b1;
        ctl.addrSel = AS_VEC1;
        ctl.capWp   = 1'b1;
        stateD      = ST_W13;
      end
      ST_W13: begin
        ctl.memReq  = 1'b1;
        ctl.memWe   = 1'b1;
        ctl.addrSel = AS_SAVE_WP;
        ctl.capPc   = 1'b1;
        stateD      = ST_W14;
      end
      ST_W14: begin
        ctl.memReq  = 1'b1;
        ctl.memWe   = 1'b1;
        ctl.addrSel = AS_SAVE_PC;
        stateD      = ST_W15;
      end
      ST_W15: begin
        ctl.memReq     = 1'b1;
        ctl.memWe      = 1'b1;
        ctl.addrSel    = AS_SAVE_ST;
        ctl.commitCall = 1'b1;
        stateD         = ST_IDLE;
      end
      ST_RT0: begin
        ctl.memReq  = 1'b1;
        ctl.addrSel = AS_RET_WP;
        stateD      = ST_RT1;
      end
      ST_RT1: begin
        ctl.memReq  = 1'b1;
        ctl.addrSel = AS_RET_PC;
        ctl.capWp   = 1'b1;
        stateD      = ST_RT2;
      end
      ST_RT2: begin
        ctl.memReq  = 1'b1;
        ctl.addrSel = AS_RET_ST;
        ctl.capPc   = 1'b1;
        stateD      = ST_RT3;
      end
      ST_RT3: begin
        ctl.commitRet = 1'b1;
        stateD        = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign busy = (stateQ != ST_IDLE);

endmodule

// File: rtl/wsctx_dp.sv
module wsctx_dp
  import wsctx_pkg::*;
#(
  parameter int          DATA_W   = 16,
  parameter int          MASK_W   = 4,
  parameter int          NUM_REGS = 16,
  parameter int unsigned RESET_PC = 'h0100,
  parameter int unsigned RESET_WP = 'h0080,
  parameter int unsigned RESET_ST = 'h000F
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [DATA_W-1:0] cmdArg,
  input  logic [MASK_W-1:0] irqLevel,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] pcOut,
  output logic [DATA_W-1:0] stOut,
  output logic [DATA_W-1:0] wpOut,
  output logic [MASK_W-1:0] stMask
);

  localparam int WORD_BYTES  = DATA_W / 8;
  localparam int VEC_SHIFT   = $clog2(2 * WORD_BYTES);
  localparam int OFS_SAVE_WP = (NUM_REGS - 3) * WORD_BYTES;
  localparam int OFS_SAVE_PC = (NUM_REGS - 2) * WORD_BYTES;
  localparam int OFS_SAVE_ST = (NUM_REGS - 1) * WORD_BYTES;

  logic [DATA_W-1:0] pcQ, stQ, wpQ, vecQ, newWpQ, newPcQ;
  logic              irqQ;
  logic [MASK_W-1:0] lvlQ, newMask;
  logic [DATA_W-1:0] irqVec;

  assign irqVec  = DATA_W'(irqLevel) << VEC_SHIFT;
  assign newMask = (lvlQ == '0) ? '0 : lvlQ - MASK_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ    <= DATA_W'(RESET_PC);
      stQ    <= DATA_W'(RESET_ST);
      wpQ    <= DATA_W'(RESET_WP);
      vecQ   <= '0;
      newWpQ <= '0;
      newPcQ <= '0;
      irqQ   <= 1'b0;
      lvlQ   <= '0;
    end else begin
      if (ctl.latchVec) begin
        vecQ <= ctl.vecFromIrq ? irqVec : cmdArg;
        irqQ <= ctl.vecFromIrq;
        lvlQ <= irqLevel;
      end
      if (ctl.capWp)     newWpQ <= memRdata;
      if (ctl.capPc)     newPcQ <= memRdata;
      if (ctl.loadWpImm) wpQ    <= cmdArg;
      if (ctl.commitCall) begin
        wpQ <= newWpQ;
        pcQ <= newPcQ;
        if (irqQ) stQ[MASK_W-1:0] <= newMask;
      end
      if (ctl.commitRet) begin
        wpQ <= newWpQ;
        pcQ <= newPcQ;
        stQ <= memRdata;
      end
    end
  end

  always_comb begin
    memAddr  = '0;
    memWdata = '0;
    case (ctl.addrSel)
      AS_VEC0:    memAddr = vecQ;
      AS_VEC1:    memAddr = vecQ + DATA_W'(WORD_BYTES);
      AS_SAVE_WP: begin
        memAddr  = newWpQ + DATA_W'(OFS_SAVE_WP);
        memWdata = wpQ;
      end
      AS_SAVE_PC: begin
        memAddr  = newWpQ + DATA_W'(OFS_SAVE_PC);
        memWdata = pcQ;
      end
      AS_SAVE_ST: begin
        memAddr  = newWpQ + DATA_W'(OFS_SAVE_ST);
        memWdata = stQ;
      end
      AS_RET_WP:  memAddr = wpQ + DATA_W'(OFS_SAVE_WP);
      AS_RET_PC:  memAddr = wpQ + DATA_W'(OFS_SAVE_PC);
      AS_RET_ST:  memAddr = wpQ + DATA_W'(OFS_SAVE_ST);
      default: ;
    endcase
  end

  assign pcOut  = pcQ;
  assign stOut  = stQ;
  assign wpOut  = wpQ;
  assign stMask = stQ[MASK_W-1:0];

endmodule

// File: rtl/wsctx_top.sv
module wsctx_top
  import wsctx_pkg::*;
#(
  parameter int          DATA_W     = 16,
  parameter int          NUM_LEVELS = 16,
  parameter int          NUM_REGS   = 16,
  parameter int unsigned RESET_PC   = 'h0100,
  parameter int unsigned RESET_WP   = 'h0080,
  parameter int unsigned RESET_ST   = 'h000F,
  localparam int         MASK_W     = $clog2(NUM_LEVELS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [DATA_W-1:0] cmdArg,
  input  logic              boundary,
  input  logic              irqReq,
  input  logic [MASK_W-1:0] irqLevel,
  output logic              memReq,
  output logic              memWe,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] pcOut,
  output logic [DATA_W-1:0] stOut,
  output logic [DATA_W-1:0] wpOut,
  output logic              busy
);

  dpCtl_t            ctl;
  logic [MASK_W-1:0] stMask;

  wsctx_ctrl #(.MASK_W(MASK_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .boundary (boundary),
    .irqReq   (irqReq),
    .irqLevel (irqLevel),
    .stMask   (stMask),
    .ctl      (ctl),
    .busy     (busy)
  );

  wsctx_dp #(
    .DATA_W   (DATA_W),
    .MASK_W   (MASK_W),
    .NUM_REGS (NUM_REGS),
    .RESET_PC (RESET_PC),
    .RESET_WP (RESET_WP),
    .RESET_ST (RESET_ST)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .cmdArg   (cmdArg),
    .irqLevel (irqLevel),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .pcOut    (pcOut),
    .stOut    (stOut),
    .wpOut    (wpOut),
    .stMask   (stMask)
  );

  assign memReq = ctl.memReq;
  assign memWe  = ctl.memWe;

endmodule

// File: rtl/wsctx_chk.sv
module wsctx_chk #(
  parameter int DATA_W = 16,
  parameter int MASK_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic [1:0]        cmdOp,
  input logic [DATA_W-1:0] cmdArg,
  input logic              boundary,
  input logic              irqReq,
  input logic [MASK_W-1:0] irqLevel,
  input logic              memReq,
  input logic              memWe,
  input logic [DATA_W-1:0] memAddr,
  input logic              busy,
  input logic [DATA_W-1:0] pcOut,
  input logic [DATA_W-1:0] stOut,
  input logic [DATA_W-1:0] wpOut
);

  logic [2:0] busyRun;

  always_ff @(posedge clk) begin
    if (!rstN)             busyRun <= '0;
    else if (!busy)        busyRun <= '0;
    else if (busyRun != 7) busyRun <= busyRun + 3'd1;
  end

  AST_LOADWP_DIRECT: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cmdValid && cmdOp == 2'd0 && !irqReq)
      |=> (wpOut == $past(cmdArg)) && !busy && !memReq); // R2

  AST_IRQ_VECTOR_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && boundary && irqReq && irqLevel <= stOut[MASK_W-1:0])
      |=> memReq && !memWe && memAddr == (DATA_W'($past(irqLevel)) << 2)); // R4

  AST_WRITE_IN_SWITCH: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (busy && memReq)); // R5

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !cmdValid && irqReq && irqLevel > stOut[MASK_W-1:0])
      |=> !busy); // R7

  AST_CTX_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy))
      |-> ($stable(wpOut) && $stable(pcOut) && $stable(stOut))); // R8

  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= 3'd5); // R8

endmodule

bind wsctx_top wsctx_chk #(.DATA_W(DATA_W), .MASK_W(MASK_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .cmdValid (cmdValid),
  .cmdOp    (cmdOp),
  .cmdArg   (cmdArg),
  .boundary (boundary),
  .irqReq   (irqReq),
  .irqLevel (irqLevel),
  .memReq   (memReq),
  .memWe    (memWe),
  .memAddr  (memAddr),
  .busy     (busy),
  .pcOut    (pcOut),
  .stOut    (stOut),
  .wpOut    (wpOut)
);

// File: tb/wsctx_top_tb_top.sv
module wsctx_top_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cmdValid;
  logic [1:0]  cmdOp;
  logic [15:0] cmdArg;
  logic        boundary;
  logic        irqReq;
  logic [3:0]  irqLevel;
  logic        memReq, memWe;
  logic [15:0] memAddr, memWdata, memRdata;
  logic [15:0] pcOut, stOut, wpOut;
  logic        busy;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [15:0] mem    [0:255];
  logic [15:0] expMem [0:255];
  logic [15:0] wrLog  [0:31];
  int          wrCnt = 0;
  logic [15:0] ePc, eSt, eWp;

  always #(CLK_PERIOD/2) clk = ~clk;

  wsctx_top dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdArg(cmdArg),
    .boundary(boundary), .irqReq(irqReq), .irqLevel(irqLevel),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .pcOut(pcOut), .stOut(stOut), .wpOut(wpOut), .busy(busy)
  );

  always @(posedge clk) begin
    if (rstN && memReq) begin
      if (memWe) begin
        mem[memAddr[8:1]] <= memWdata;
        wrLog[wrCnt % 32] <= memAddr;
        wrCnt <= wrCnt + 1;
      end else begin
        memRdata <= mem[memAddr[8:1]];
      end
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic checkCtx(input string tag);
    chk({tag, " pc"}, pcOut, ePc);
    chk({tag, " wp"}, wpOut, eWp);
    chk({tag, " st"}, stOut, eSt);
  endtask

  task automatic checkMem(input string tag);
    int bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== expMem[i]) bad++;
    chk({tag, " memory mismatches"}, 16'(bad), 16'd0);
  endtask

  task automatic waitIdle(output int n);
    n = 0;
    while (busy === 1'b1 && n < 50) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic modelSwitch(input logic [15:0] vec, input bit isIrq, input logic [3:0] lvl);
    logic [15:0] nWp, nPc;
    nWp = expMem[vec[8:1]];
    nPc = expMem[vec[8:1] + 8'd1];
    expMem[(nWp[8:1]) + 8'd13] = eWp;
    expMem[(nWp[8:1]) + 8'd14] = ePc;
    expMem[(nWp[8:1]) + 8'd15] = eSt;
    eWp = nWp;
    ePc = nPc;
    if (isIrq) eSt[3:0] = (lvl == 4'd0) ? 4'd0 : lvl - 4'd1;
  endtask

  task automatic modelReturn();
    logic [15:0] w;
    w   = eWp;
    eWp = expMem[w[8:1] + 8'd13];
    ePc = expMem[w[8:1] + 8'd14];
    eSt = expMem[w[8:1] + 8'd15];
  endtask

  task automatic issueCmd(input logic [1:0] op, input logic [15:0] arg, input bit poke, output int n);
    int m;
    cmdValid = 1'b1; cmdOp = op; cmdArg = arg;
    @(negedge clk);
    cmdValid = 1'b0;
    n = 0;
    if (poke && busy) begin
      cmdValid = 1'b1; cmdOp = 2'd0; cmdArg = 16'h01F0;
      irqReq = 1'b1; irqLevel = 4'd0; boundary = 1'b1;
      @(negedge clk);
      cmdValid = 1'b0; irqReq = 1'b0; boundary = 1'b0;
      n = 1;
    end
    waitIdle(m);
    n += m;
  endtask

  task automatic issueIrq(input logic [3:0] lvl, output int n);
    boundary = 1'b1; irqReq = 1'b1; irqLevel = lvl;
    @(negedge clk);
    boundary = 1'b0; irqReq = 1'b0;
    waitIdle(n);
  endtask

  task automatic testReset();
    chk("R1 reset pc", pcOut, 16'h0100);
    chk("R1 reset wp", wpOut, 16'h0080);
    chk("R1 reset st", stOut, 16'h000F);
    chk("R1 reset busy", 16'(busy), 16'd0);
    chk("R1 reset memReq", 16'(memReq), 16'd0);
    ePc = 16'h0100; eWp = 16'h0080; eSt = 16'h000F;
  endtask

  task automatic testLoadWp();
    int n, w0;
    w0 = wrCnt;
    issueCmd(2'd0, 16'h00A0, 1'b0, n);
    eWp = 16'h00A0;
    chk("R2 loadwp busy cycles", 16'(n), 16'd0);
    checkCtx("R2 loadwp");
    chk("R2 loadwp no writes", 16'(wrCnt - w0), 16'd0);
    checkMem("R2 loadwp");
  endtask

  task automatic testNested();
    int n, w0;
    logic [15:0] wSave;
    // call through vector at 0x40, with ignored stimulus while busy (R8)
    w0 = wrCnt;
    issueCmd(2'd1, 16'h0040, 1'b1, n);
    modelSwitch(16'h0040, 1'b0, 4'd0);
    chk("R8 call busy cycles", 16'(n), 16'd5);
    checkCtx("R3 call");
    checkMem("R5 call saves");
    chk("R5 save order 1", wrLog[w0 % 32], 16'h00DA);
    chk("R5 save order 2", wrLog[(w0 + 1) % 32], 16'h00DC);
    chk("R5 save order 3", wrLog[(w0 + 2) % 32], 16'h00DE);
    chk("R8 write count", 16'(wrCnt - w0), 16'd3);
    // request without boundary is refused (R7)
    irqReq = 1'b1; irqLevel = 4'd3; boundary = 1'b0;
    @(negedge clk); @(negedge clk);
    irqReq = 1'b0;
    chk("R7 no boundary busy", 16'(busy), 16'd0);
    chk("R7 no boundary wp", wpOut, eWp);
    // interrupt level 3 inside the call
    issueIrq(4'd3, n);
    modelSwitch(16'h000C, 1'b1, 4'd3);
    chk("R8 irq busy cycles", 16'(n), 16'd5);
    checkCtx("R4 R7 irq3");
    checkMem("R5 irq saves");
    // level above mask 2 refused (R7)
    wSave = wpOut;
    boundary = 1'b1; irqReq = 1'b1; irqLevel = 4'd5;
    @(negedge clk); @(negedge clk);
    boundary = 1'b0; irqReq = 1'b0;
    chk("R7 masked busy", 16'(busy), 16'd0);
    chk("R7 masked wp", wpOut, wSave);
    // two returns unwind the nesting
    issueCmd(2'd2, 16'h0000, 1'b0, n);
    modelReturn();
    chk("R8 return busy cycles", 16'(n), 16'd4);
    checkCtx("R6 return 1");
    issueCmd(2'd2, 16'h0000, 1'b0, n);
    modelReturn();
    checkCtx("R6 return 2");
    chk("R6 final wp", wpOut, 16'h00A0);
    checkMem("R6 returns");
  endtask

  task automatic testPriority();
    int n;
    logic [15:0] wSave;
    boundary = 1'b1; irqReq = 1'b1; irqLevel = 4'd1;
    cmdValid = 1'b1; cmdOp = 2'd0; cmdArg = 16'h01F0;
    @(negedge clk);
    boundary = 1'b0; irqReq = 1'b0; cmdValid = 1'b0;
    waitIdle(n);
    modelSwitch(16'h0004, 1'b1, 4'd1);
    chk("R9 irq wins busy", 16'(n), 16'd5);
    checkCtx("R9 R7 irq1");
    checkMem("R9 irq1");
    issueCmd(2'd2, 16'h0000, 1'b0, n);
    modelReturn();
    checkCtx("R6 return from irq1");
    wSave = wpOut;
    cmdValid = 1'b1; cmdOp = 2'd3; cmdArg = 16'h0150;
    @(negedge clk);
    cmdValid = 1'b0;
    chk("R9 op3 busy", 16'(busy), 16'd0);
    chk("R9 op3 memReq", 16'(memReq), 16'd0);
    chk("R9 op3 wp", wpOut, wSave);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'hA500 ^ 16'(i);
    mem[8'h20] = 16'h00C0; mem[8'h21] = 16'h0200;
    mem[8'h06] = 16'h0100; mem[8'h07] = 16'h0300;
    mem[8'h02] = 16'h0140; mem[8'h03] = 16'h0400;
    for (int i = 0; i < 256; i++) expMem[i] = mem[i];
    memRdata = '0;
    rstN = 1'b0; cmdValid = 1'b0; cmdOp = 2'd3; cmdArg = '0;
    boundary = 1'b0; irqReq = 1'b0; irqLevel = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLoadWp();
    testNested();
    testPriority();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule